// File: doc/BRIEF.md
# Protection Fault Qualifier and Inhibit Output Controller

This block sits behind the analog comparators of a multi-cell battery protector. It receives one raw flag for each fault class: cell too high, cell too low, broken sense wire, pack too hot, and a stalled internal oscillator. A raw flag only acts on the pack after it has stayed asserted for that class's qualification time. The time is counted in milliseconds by a prescaled tick. If the flag drops before the time runs out, the count starts over.

Qualified faults are routed to two inhibit outputs, one that blocks charging and one that blocks discharging. Each output drives its pad as a push-pull high-true level or as a low-true open-drain pull. A configuration bit can make every fault sticky until reset. A test mode shortens every delay. That mode is entered and left through a digitized measurement of how far the supply sits above the top cell, with hysteresis.

Top module: `fault_qualifier`

## Requirements
- R1: The delay codes for over-voltage, under-voltage and over-temperature select DLY_BASE_MS shifted left by the code: 0 gives 1x, 1 gives 2x, 2 gives 4x, 3 gives 8x and 4 gives 16x (250, 500, 1000, 2000 and 4000 ms by default). Codes 5 to 7 act as code 4. The broken-wire delay is always 16x. A class output becomes active after at least (N-1) and at most N millisecond ticks of an uninterrupted raw flag, where N is its delay in ms.
- R2: If a raw flag drops before its delay expires, the output stays inactive and the count is discarded. A later assertion needs the full delay again.
- R3: A qualified over-voltage activates only the charge inhibit. A qualified under-voltage activates only the discharge inhibit.
- R4: A qualified broken wire or over-temperature activates both inhibits.
- R5: An enabled oscillator failure activates both inhibits one clock after `osc_bad` is seen, without any delay. Without latching, both inhibits release one clock after `osc_bad` clears.
- R6: With `latch_en` high, an inhibit that has become active stays active until `rst`, whatever the raw flags do.
- R7: With the polarity bit at 1, the output is push-pull: `*_oe` is 1 and `*_pin` equals the fault state. With the polarity bit at 0, the output is open-drain: `*_pin` is 0 and `*_oe` is 1 only during a fault.
- R8: `test_mode` sets once `sup_gap` is at least TM_ENTER (12) and clears once `sup_gap` falls below TM_EXIT (10). Between those values it holds. While it is set, every class, the broken wire included, uses a delay of TEST_MS.
- R9: The bits of `class_en` are ordered over-voltage=0, under-voltage=1, broken wire=2, over-temperature=3, oscillator=4. A class whose bit is 0 never activates an output.
- R10: Without latching, a qualified class stays active while its raw flag stays high. It releases one clock after the flag clears.
- R11: `fault_mode` is 1 exactly when either inhibit is active.
- R12: After reset, both inhibits are inactive and both `test_mode` and `fault_mode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| raw_ov | input | 1 | Raw cell over-voltage flag |
| raw_uv | input | 1 | Raw cell under-voltage flag |
| raw_ow | input | 1 | Raw broken sense wire flag |
| raw_ot | input | 1 | Raw over-temperature flag |
| osc_bad | input | 1 | Oscillator failure flag |
| class_en | input | 5 | Per-class enable, order as in R9 |
| ov_dly | input | 3 | Over-voltage delay code |
| uv_dly | input | 3 | Under-voltage delay code |
| ot_dly | input | 3 | Over-temperature delay code |
| latch_en | input | 1 | Make faults sticky until reset |
| chg_pol | input | 1 | Charge inhibit polarity (1 push-pull high, 0 open-drain low) |
| dsg_pol | input | 1 | Discharge inhibit polarity |
| sup_gap | input | GAP_W | Digitized supply-minus-top-cell difference in volts |
| chg_pin | output | 1 | Charge inhibit pad level |
| chg_oe | output | 1 | Charge inhibit pad drive enable |
| dsg_pin | output | 1 | Discharge inhibit pad level |
| dsg_oe | output | 1 | Discharge inhibit pad drive enable |
| fault_mode | output | 1 | 1 while either inhibit is active |
| test_mode | output | 1 | 1 while delays are shortened |

## Verification
The bench builds the block with CLK_PER_MS=3, DLY_BASE_MS=8 and TEST_MS=3. With these values the longest delay is 384 clocks, so every delay code, the fixed broken-wire delay and the clamped codes can each be timed against both edges of their qualification window. The small prescaler also gives the free-running tick several possible phases, so the window bounds in R1 are exercised rather than one exact cycle. The shortened test delay lets a single run cover entry, hold inside the hysteresis band and exit of the test mode.

// File: rtl/fq_pkg.sv
package fq_pkg;

    // Timed fault classes; values index raw/enable/qualified vectors.
    typedef enum logic [1:0] {
        CL_OV = 2'd0,
        CL_UV = 2'd1,
        CL_OW = 2'd2,
        CL_OT = 2'd3
    } fq_class_e;

    localparam int          NUM_TIMED    = 4;
    localparam int          OSC_BIT      = 4;
    localparam int          NUM_EN       = NUM_TIMED + 1;
    localparam logic [2:0]  LONGEST_CODE = 3'd4;

    // Which inhibit outputs a class acts on.
    typedef struct packed {
        logic chg;
        logic dsg;
    } fq_route_t;

    // Pad drive pair.
    typedef struct packed {
        logic pin;
        logic oe;
    } fq_drive_t;

    function automatic fq_route_t route_of(fq_class_e c);
        fq_route_t r;
        case (c)
            CL_OV:   r = '{chg: 1'b1, dsg: 1'b0};
            CL_UV:   r = '{chg: 1'b0, dsg: 1'b1};
            default: r = '{chg: 1'b1, dsg: 1'b1};
        endcase
        return r;
    endfunction

    // Delay in ms for a code; codes above the longest clamp to it.
    function automatic int unsigned delay_ms(logic [2:0] code, int unsigned base);
        logic [2:0] c;
        c = (code > LONGEST_CODE) ? LONGEST_CODE : code;
        return base << c;
    endfunction

    // High-true push-pull or low-true open-drain.
    function automatic fq_drive_t drive_of(logic push_pull_high, logic fault);
        fq_drive_t d;
        if (push_pull_high) begin
            d.pin = fault;
            d.oe  = 1'b1;
        end else begin
            d.pin = 1'b0;
            d.oe  = fault;
        end
        return d;
    endfunction

endpackage

// File: rtl/fq_ms_tick.sv
module fq_ms_tick #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [TW-1:0] LAST = TW'(DIV - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);

    generate
        if (DIV > 1) begin : g_spacing
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);  // R1
        end
    endgenerate

endmodule

// File: rtl/fq_qual_timer.sv
module fq_qual_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          act,
    input  logic          latch,
    input  logic [CW-1:0] limit,
    output logic          qual
);
    logic [CW-1:0] cnt;
    logic [CW:0]   cnt_nx;

    assign cnt_nx = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            qual <= 1'b0;
        end else if (qual) begin
            cnt <= '0;
            if (!latch && !act) begin
                qual <= 1'b0;
            end
        end else if (!act) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt_nx >= {1'b0, limit}) begin
                qual <= 1'b1;
                cnt  <= '0;
            end else begin
                cnt <= cnt_nx[CW-1:0];
            end
        end
    end

    AST_QUAL_NEEDS_ACT: assert property (@(posedge clk) disable iff (rst)
        $rose(qual) |-> ($past(act) && $past(tick)));  // R2

    AST_RELEASE_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        (qual && !latch && !act) |=> !qual);  // R10

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (qual && latch) |=> qual);  // R6

endmodule

// File: rtl/fq_test_gate.sv
module fq_test_gate #(
    parameter int GAP_W    = 7,
    parameter int TM_ENTER = 12,
    parameter int TM_EXIT  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [GAP_W-1:0] sup_gap,
    output logic             tm
);
    localparam logic [GAP_W-1:0] ENTER_LVL = GAP_W'(TM_ENTER);
    localparam logic [GAP_W-1:0] EXIT_LVL  = GAP_W'(TM_EXIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            tm <= 1'b0;
        end else if (tm) begin
            tm <= (sup_gap >= EXIT_LVL);
        end else begin
            tm <= (sup_gap >= ENTER_LVL);
        end
    end

    AST_TM_HOLD_IN_BAND: assert property (@(posedge clk) disable iff (rst)
        (tm && sup_gap >= EXIT_LVL) |=> tm);  // R8

    AST_TM_NO_EARLY_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (!tm && sup_gap < ENTER_LVL) |=> !tm);  // R8

endmodule

// File: rtl/fault_qualifier.sv
module fault_qualifier
    import fq_pkg::*;
#(
    parameter int CLK_PER_MS  = 1000,
    parameter int DLY_BASE_MS = 250,
    parameter int TEST_MS     = 100,
    parameter int GAP_W       = 7,
    parameter int TM_ENTER    = 12,
    parameter int TM_EXIT     = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_ov,
    input  logic             raw_uv,
    input  logic             raw_ow,
    input  logic             raw_ot,
    input  logic             osc_bad,
    input  logic [4:0]       class_en,
    input  logic [2:0]       ov_dly,
    input  logic [2:0]       uv_dly,
    input  logic [2:0]       ot_dly,
    input  logic             latch_en,
    input  logic             chg_pol,
    input  logic             dsg_pol,
    input  logic [GAP_W-1:0] sup_gap,
    output logic             chg_pin,
    output logic             chg_oe,
    output logic             dsg_pin,
    output logic             dsg_oe,
    output logic             fault_mode,
    output logic             test_mode
);
    localparam int LONG_MS = DLY_BASE_MS << LONGEST_CODE;
    localparam int MAX_MS  = (LONG_MS > TEST_MS) ? LONG_MS : TEST_MS;
    localparam int CW      = $clog2(MAX_MS + 1);

    logic                         tick;
    logic                         tm;
    logic [NUM_TIMED-1:0]         raw_vec;
    logic [NUM_TIMED-1:0]         qual;
    logic [NUM_TIMED-1:0][2:0]    dly_sel;
    logic [NUM_TIMED-1:0][CW-1:0] limit;
    logic                         osc_q;
    logic                         chg_flt;
    logic                         dsg_flt;
    fq_drive_t                    chg_drv;
    fq_drive_t                    dsg_drv;

    fq_ms_tick #(.DIV(CLK_PER_MS)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    fq_test_gate #(
        .GAP_W    (GAP_W),
        .TM_ENTER (TM_ENTER),
        .TM_EXIT  (TM_EXIT)
    ) u_gate (
        .clk     (clk),
        .rst     (rst),
        .sup_gap (sup_gap),
        .tm      (tm)
    );

    assign raw_vec = {raw_ot, raw_ow, raw_uv, raw_ov};

    always_comb begin
        dly_sel        = '0;
        dly_sel[CL_OV] = ov_dly;
        dly_sel[CL_UV] = uv_dly;
        dly_sel[CL_OW] = LONGEST_CODE;
        dly_sel[CL_OT] = ot_dly;
    end

    generate
        for (genvar i = 0; i < NUM_TIMED; i++) begin : g_class
            assign limit[i] = tm ? CW'(TEST_MS)
                                 : CW'(delay_ms(dly_sel[i], DLY_BASE_MS));

            fq_qual_timer #(.CW(CW)) u_timer (
                .clk   (clk),
                .rst   (rst),
                .tick  (tick),
                .act   (raw_vec[i] & class_en[i]),
                .latch (latch_en),
                .limit (limit[i]),
                .qual  (qual[i])
            );

            AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
                (!class_en[i] && !qual[i]) |=> !qual[i]);  // R9
        end
    endgenerate

    // Oscillator failure bypasses qualification.
    always_ff @(posedge clk) begin
        if (rst) begin
            osc_q <= 1'b0;
        end else begin
            osc_q <= (osc_bad & class_en[OSC_BIT]) | (latch_en & osc_q);
        end
    end

    always_comb begin
        fq_route_t r;
        chg_flt = osc_q;
        dsg_flt = osc_q;
        for (int k = 0; k < NUM_TIMED; k++) begin
            r       = route_of(fq_class_e'(k));
            chg_flt = chg_flt | (qual[k] & r.chg);
            dsg_flt = dsg_flt | (qual[k] & r.dsg);
        end
    end

    assign chg_drv    = drive_of(chg_pol, chg_flt);
    assign dsg_drv    = drive_of(dsg_pol, dsg_flt);
    assign chg_pin    = chg_drv.pin;
    assign chg_oe     = chg_drv.oe;
    assign dsg_pin    = dsg_drv.pin;
    assign dsg_oe     = dsg_drv.oe;
    assign fault_mode = chg_flt | dsg_flt;
    assign test_mode  = tm;

    AST_OSC_BOTH: assert property (@(posedge clk) disable iff (rst)
        (osc_bad && class_en[OSC_BIT]) |=> (chg_flt && dsg_flt));  // R5

    AST_OV_SPARES_DSG: assert property (@(posedge clk) disable iff (rst)
        (dsg_flt && !osc_q) |-> (qual[CL_UV] || qual[CL_OW] || qual[CL_OT]));  // R3

    AST_MODE_MATCHES_PADS: assert property (@(posedge clk) disable iff (rst)
        fault_mode == ((chg_pol ? chg_pin : (chg_oe && !chg_pin)) ||
                       (dsg_pol ? dsg_pin : (dsg_oe && !dsg_pin))));  // R11

endmodule

// File: tb/fault_qualifier_tb.sv
module fault_qualifier_tb;

    localparam int P     = 3;
    localparam int BASE  = 8;
    localparam int TMS   = 3;
    localparam int GAP_W = 7;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             raw_ov = 0, raw_uv = 0, raw_ow = 0, raw_ot = 0, osc_bad = 0;
    logic [4:0]       class_en = 5'b11111;
    logic [2:0]       ov_dly = 0, uv_dly = 0, ot_dly = 0;
    logic             latch_en = 0;
    logic             chg_pol = 1, dsg_pol = 1;
    logic [GAP_W-1:0] sup_gap = 0;
    logic             chg_pin, chg_oe, dsg_pin, dsg_oe, fault_mode, test_mode;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;  // 250 MHz

    fault_qualifier #(
        .CLK_PER_MS  (P),
        .DLY_BASE_MS (BASE),
        .TEST_MS     (TMS),
        .GAP_W       (GAP_W),
        .TM_ENTER    (12),
        .TM_EXIT     (10)
    ) u_dut (
        .clk(clk), .rst(rst),
        .raw_ov(raw_ov), .raw_uv(raw_uv), .raw_ow(raw_ow), .raw_ot(raw_ot),
        .osc_bad(osc_bad), .class_en(class_en),
        .ov_dly(ov_dly), .uv_dly(uv_dly), .ot_dly(ot_dly),
        .latch_en(latch_en), .chg_pol(chg_pol), .dsg_pol(dsg_pol),
        .sup_gap(sup_gap),
        .chg_pin(chg_pin), .chg_oe(chg_oe), .dsg_pin(dsg_pin), .dsg_oe(dsg_oe),
        .fault_mode(fault_mode), .test_mode(test_mode)
    );

    function automatic logic chg_act();
        return chg_pol ? chg_pin : (chg_oe && !chg_pin);
    endfunction

    function automatic logic dsg_act();
        return dsg_pol ? dsg_pin : (dsg_oe && !dsg_pin);
    endfunction

    task automatic chk(string req, string what, logic actual, logic expected);
        total++;
        if (actual !== expected) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, actual, expected);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Raw flag was just driven; check both edges of the delay window.
    task automatic window(string req, int ms, logic exp_c, logic exp_d);
        cyc((ms - 1) * P);
        chk(req, "chg before expiry", chg_act(), 1'b0);
        chk(req, "dsg before expiry", dsg_act(), 1'b0);
        cyc(P);
        chk(req, "chg after expiry", chg_act(), exp_c);
        chk(req, "dsg after expiry", dsg_act(), exp_d);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        cyc(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R12", "chg idle", chg_act(), 1'b0);
        chk("R12", "dsg idle", dsg_act(), 1'b0);
        chk("R12", "test_mode", test_mode, 1'b0);
        chk("R12", "fault_mode", fault_mode, 1'b0);
    endtask

    task automatic t_ov();
        ov_dly = 3'd0; raw_ov = 1;
        window("R1 R3", BASE, 1'b1, 1'b0);
        chk("R11", "fault_mode on", fault_mode, 1'b1);
        cyc(10);
        chk("R10", "held while raw", chg_act(), 1'b1);
        raw_ov = 0;
        cyc(1);
        chk("R10", "release", chg_act(), 1'b0);
        chk("R11", "fault_mode off", fault_mode, 1'b0);
    endtask

    task automatic t_uv();
        uv_dly = 3'd2; raw_uv = 1;
        window("R1 R3", BASE * 4, 1'b0, 1'b1);
        raw_uv = 0; cyc(1);
        chk("R10", "uv release", dsg_act(), 1'b0);
    endtask

    task automatic t_retrigger();
        ov_dly = 3'd1; raw_ov = 1;
        cyc((BASE * 2 - 2) * P);
        raw_ov = 0; cyc(2);
        chk("R2", "no output on early drop", chg_act(), 1'b0);
        raw_ov = 1;
        window("R2", BASE * 2, 1'b1, 1'b0);
        raw_ov = 0; cyc(1);
    endtask

    task automatic t_ow();
        ov_dly = 0; uv_dly = 0; ot_dly = 0; raw_ow = 1;
        window("R1 R4", BASE * 16, 1'b1, 1'b1);
        raw_ow = 0; cyc(1);
        chk("R10", "ow release", fault_mode, 1'b0);
    endtask

    task automatic t_ot();
        ot_dly = 3'd3; raw_ot = 1;
        window("R4", BASE * 8, 1'b1, 1'b1);
        raw_ot = 0; cyc(1);
        ot_dly = 3'd6; raw_ot = 1;
        window("R1", BASE * 16, 1'b1, 1'b1);
        raw_ot = 0; cyc(1);
    endtask

    task automatic t_disable();
        class_en = 5'b11110; ov_dly = 0; raw_ov = 1;
        cyc(BASE * P * 4);
        chk("R9", "disabled ov", chg_act(), 1'b0);
        raw_ov = 0;
        class_en = 5'b01111; osc_bad = 1;
        cyc(3);
        chk("R9", "disabled osc", fault_mode, 1'b0);
        osc_bad = 0;
        class_en = 5'b11111;
        cyc(1);
    endtask

    task automatic t_osc();
        osc_bad = 1; cyc(1);
        chk("R5", "osc chg", chg_act(), 1'b1);
        chk("R5", "osc dsg", dsg_act(), 1'b1);
        osc_bad = 0; cyc(1);
        chk("R5", "osc release", fault_mode, 1'b0);
    endtask

    task automatic t_polarity();
        chg_pol = 0; dsg_pol = 1; cyc(1);
        chk("R7", "od idle oe", chg_oe, 1'b0);
        chk("R7", "pp idle oe", dsg_oe, 1'b1);
        chk("R7", "pp idle pin", dsg_pin, 1'b0);
        osc_bad = 1; cyc(1);
        chk("R7", "od fault oe", chg_oe, 1'b1);
        chk("R7", "od fault pin", chg_pin, 1'b0);
        chk("R7", "pp fault pin", dsg_pin, 1'b1);
        osc_bad = 0; cyc(1);
        chg_pol = 1;
    endtask

    task automatic t_testmode();
        sup_gap = 11; cyc(3);
        chk("R8", "below entry", test_mode, 1'b0);
        sup_gap = 12; cyc(1);
        chk("R8", "entered", test_mode, 1'b1);
        raw_ow = 1;
        window("R8", TMS, 1'b1, 1'b1);
        raw_ow = 0; cyc(1);
        uv_dly = 3'd4; raw_uv = 1;
        window("R8", TMS, 1'b0, 1'b1);
        raw_uv = 0;
        sup_gap = 10; cyc(3);
        chk("R8", "held in band", test_mode, 1'b1);
        sup_gap = 9; cyc(1);
        chk("R8", "exited", test_mode, 1'b0);
    endtask

    task automatic t_latch();
        latch_en = 1;
        osc_bad = 1; cyc(1);
        osc_bad = 0; cyc(5);
        chk("R6", "osc latched", dsg_act(), 1'b1);
        do_reset();
        chk("R6", "cleared by reset", fault_mode, 1'b0);
        ov_dly = 0; raw_ov = 1;
        cyc(BASE * P + 2);
        raw_ov = 0; cyc(20);
        chk("R6", "ov latched", chg_act(), 1'b1);
        chk("R6", "ov latch no dsg", dsg_act(), 1'b0);
        latch_en = 0;
        do_reset();
        chk("R12", "clean after reset", fault_mode, 1'b0);
    endtask

    initial begin
        t_reset();
        t_ov();
        t_uv();
        t_retrigger();
        t_ow();
        t_ot();
        t_disable();
        t_osc();
        t_polarity();
        t_testmode();
        t_latch();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule